// File: doc/BRIEF.md
# Single-Cycle Load/Store Core with Memory Wait

This block is a 32-bit processor core that completes one instruction per clock cycle when data memory answers at once. It runs a small set of a classic load/store instruction set: register-register arithmetic and logic, immediate arithmetic and logic, word loads and stores, and branches on equal and not-equal. The instruction word arrives combinationally on the fetch port, addressed by the current program counter. A data-memory port presents an address, write data, and separate read and write requests.

Data memory may take any number of cycles to answer. While a load or store waits for its acknowledge, the core holds the program counter and blocks the register write. The memory request stays on the port, and the instruction retires in the cycle the acknowledge arrives. Instructions that do not touch memory ignore the acknowledge.

Top module: `scc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and every register to 0.
- R2: Opcode 000000 selects a register-register operation by funct: 100001 add, 100011 subtract (rs minus rt), 100100 AND, 100101 OR, 101010 signed set-less-than. The 32-bit result is written to rd (bits 15:11). Operands are rs (bits 25:21) and rt (bits 20:16).
- R3: Opcodes 001001 (add immediate) and 001010 (signed set-less-than immediate) use the 16-bit immediate in bits 15:0, sign-extended, and write the result to rt.
- R4: Opcodes 001100 (AND immediate) and 001101 (OR immediate) use the immediate zero-extended and write the result to rt.
- R5: Opcode 100011 (load) asserts the read request with address rs plus the sign-extended immediate, and writes the returned word to rt.
- R6: Opcode 101011 (store) asserts the write request with the same address rule and puts register rt on the write data.
- R7: Opcode 000100 branches when rs equals rt, and opcode 000101 branches when they differ. A taken branch loads PC+4 plus the sign-extended immediate shifted left by two. Otherwise the PC advances by 4.
- R8: While a read or write request is present and the acknowledge is low, the PC holds and no register is written. The request, address and write data stay unchanged until the acknowledge cycle, in which the instruction completes.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: An unrecognised opcode, or opcode 000000 with an unlisted funct, writes no register, makes no memory request and advances the PC by 4.
- R11: Instructions other than load and store make no memory request, and their progress does not depend on the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data-memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rd | output | 1 | Read request |
| dmem_wr | output | 1 | Write request |
| dmem_rdata | input | 32 | Load data, valid with the acknowledge |
| dmem_ack | input | 1 | Data-memory acknowledge |

## Verification
The hard case is a memory access that waits several cycles behind a low acknowledge. The bench must show that nothing moves during the wait and that the result lands exactly once. This includes a load whose destination is then used as a store address base. The bench replays one program under three acknowledge patterns: always high, a pseudo-random bit, and high only one cycle in four. A mid-run reset sits between the runs. Every stored value is tagged with the instruction class that produced it, so a wrong register result is reported against its own requirement when a later store exposes it.

// File: rtl/scc_pkg.sv
package scc_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_BNE   = 6'b000101;
    localparam logic [5:0] OPC_ADDIU = 6'b001001;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADDU = 6'b100001;
    localparam logic [5:0] FN_SUBU = 6'b100011;
    localparam logic [5:0] FN_AND  = 6'b100100;
    localparam logic [5:0] FN_OR   = 6'b100101;
    localparam logic [5:0] FN_SLT  = 6'b101010;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    reg_we;
        logic    dst_rd;
        logic    use_imm;
        logic    imm_zext;
        logic    mem_rd;
        logic    mem_wr;
        logic    br_eq;
        logic    br_ne;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]  opc;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [4:0]  sh;
        logic [5:0]  fn;
    } iword_t;

    function automatic logic [XLEN-1:0] ext16(input logic [15:0] v, input logic zext);
        return zext ? {{(XLEN-16){1'b0}}, v} : {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/scc_decode.sv
module scc_decode
    import scc_pkg::*;
(
    input  iword_t iw,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (iw.opc)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                unique case (iw.fn)
                    FN_ADDU: ctrl.alu_op = ALU_ADD;
                    FN_SUBU: ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDIU: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OPC_SLTI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
            end
            OPC_ANDI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu_op   = ALU_AND;
            end
            OPC_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            OPC_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: ctrl.br_eq = 1'b1;
            OPC_BNE: ctrl.br_ne = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/scc_alu.sv
module scc_alu
    import scc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [N];

    assign regs[0] = '0;

    for (genvar i = 1; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && wa == AW'(i))
                regs[i] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/scc_core.sv
module scc_core
    import scc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREGS,
    localparam int AW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] imem_addr,
    input  logic [31:0]  imem_data,
    output logic [W-1:0] dmem_addr,
    output logic [W-1:0] dmem_wdata,
    output logic         dmem_rd,
    output logic         dmem_wr,
    input  logic [W-1:0] dmem_rdata,
    input  logic         dmem_ack
);

    iword_t       iw;
    ctrl_t        ctrl;
    logic [W-1:0] pc_q, pc_seq, pc_br, pc_d;
    logic [W-1:0] src_a, src_b, imm_x, alu_b, alu_y, wb_val;
    logic [AW-1:0] wb_idx;
    logic         wait_mem, wb_en, br_take;

    assign iw = iword_t'(imem_data);

    scc_decode u_dec (
        .iw   (iw),
        .ctrl (ctrl)
    );

    scc_regfile #(.W(W), .N(N)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (iw.rs[AW-1:0]),
        .ra_b (iw.rt[AW-1:0]),
        .rd_a (src_a),
        .rd_b (src_b),
        .we   (wb_en),
        .wa   (wb_idx),
        .wd   (wb_val)
    );

    assign imm_x = ext16({iw.rd, iw.sh, iw.fn}, ctrl.imm_zext);
    assign alu_b = ctrl.use_imm ? imm_x : src_b;

    scc_alu #(.W(W)) u_alu (
        .a  (src_a),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    // memory side and wait condition
    assign dmem_addr  = alu_y;
    assign dmem_wdata = src_b;
    assign dmem_rd    = ctrl.mem_rd;
    assign dmem_wr    = ctrl.mem_wr;
    assign wait_mem   = (ctrl.mem_rd | ctrl.mem_wr) & ~dmem_ack;

    // writeback
    assign wb_idx = ctrl.dst_rd ? iw.rd[AW-1:0] : iw.rt[AW-1:0];
    assign wb_val = ctrl.mem_rd ? dmem_rdata : alu_y;
    assign wb_en  = ctrl.reg_we & ~wait_mem;

    // next PC
    assign br_take = (ctrl.br_eq & (src_a == src_b)) | (ctrl.br_ne & (src_a != src_b));
    assign pc_seq  = pc_q + W'(4);
    assign pc_br   = pc_seq + {imm_x[W-3:0], 2'b00};
    assign pc_d    = br_take ? pc_br : pc_seq;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (!wait_mem)
            pc_q <= pc_d;
    end

    assign imem_addr = pc_q;

endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic [31:0] dmem_addr,
    input logic [31:0] dmem_wdata,
    input logic        dmem_rd,
    input logic        dmem_wr,
    input logic        dmem_ack
);

    logic is_br;
    assign is_br = (imem_data[31:26] == 6'b000100) || (imem_data[31:26] == 6'b000101);

    AST_RESET_PC: assert property (@(posedge clk) rst |=> imem_addr == 32'd0); // R1

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr)); // R6

    AST_WAIT_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
        ((dmem_rd || dmem_wr) && !dmem_ack) |=> imem_addr == $past(imem_addr)); // R8

    AST_WAIT_HOLD_STORE: assert property (@(posedge clk) disable iff (rst)
        (dmem_wr && !dmem_ack) |=> dmem_wr && $stable(dmem_addr) && $stable(dmem_wdata)); // R8

    AST_LOAD_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (dmem_rd && dmem_ack) |=> imem_addr == $past(imem_addr) + 32'd4); // R5

    AST_PLAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!dmem_rd && !dmem_wr && !is_br) |=> imem_addr == $past(imem_addr) + 32'd4); // R11

endmodule

bind scc_core scc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr),
    .dmem_ack   (dmem_ack)
);

// File: tb/scc_core_bench.sv
module scc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd, dmem_wr, dmem_ack;

    always #5 clk = ~clk;

    scc_core u_scc_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .dmem_rdata (dmem_rdata),
        .dmem_ack   (dmem_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] prog [64];
    logic [31:0] mem  [32];
    logic [31:0] m_reg [32];
    string       m_wtag [32];
    logic [31:0] m_pc;
    string       pc_tag;
    logic [15:0] lf = 16'hACE1;
    int          cyc = 0;

    function automatic logic [31:0] e_r(int fn, int rs, int rt, int rd);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] e_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic model_reset();
        m_pc = 0;
        pc_tag = "R1";
        for (int i = 0; i < 32; i++) begin
            m_reg[i]  = 0;
            m_wtag[i] = (i == 0) ? "R9" : "R1";
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        imem_data = 0;
        dmem_ack = 1'b0;
        dmem_rdata = 0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", imem_addr, 32'd0);
        rst = 1'b0;
        model_reset();
    endtask

    function automatic string classify(logic [31:0] ins);
        logic [5:0] op = ins[31:26];
        logic [5:0] fn = ins[5:0];
        case (op)
            6'b000000: return (fn == 6'b100001 || fn == 6'b100011 || fn == 6'b100100 ||
                               fn == 6'b100101 || fn == 6'b101010) ? "R2" : "R10";
            6'b001001, 6'b001010: return "R3";
            6'b001100, 6'b001101: return "R4";
            6'b100011: return "R5";
            6'b101011: return "R6";
            6'b000100, 6'b000101: return "R7";
            default:   return "R10";
        endcase
    endfunction

    // mode 0: ack always high, 1: pseudo-random, 2: one cycle in four
    task automatic run_phase(int mode, int ncyc);
        for (int k = 0; k < ncyc; k++) begin
            logic [31:0] ins, a, b, sx, zx, ea, res;
            logic [5:0]  op, fn;
            int          rs, rt, rd, dst;
            logic        want_rd, want_wr, ack, stall, wr_en;
            string       cls;
            cyc++;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ack = (mode == 0) ? 1'b1 : (mode == 1) ? lf[0] : (cyc % 4 == 3);
            ins = prog[m_pc[7:2]];
            op = ins[31:26]; fn = ins[5:0];
            rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
            a = m_reg[rs]; b = m_reg[rt];
            sx = {{16{ins[15]}}, ins[15:0]};
            zx = {16'd0, ins[15:0]};
            ea = a + sx;
            cls = classify(ins);
            want_rd = (op == 6'b100011);
            want_wr = (op == 6'b101011);
            imem_data  = ins;
            dmem_ack   = ack;
            dmem_rdata = mem[ea[6:2]];
            #1;
            chk(pc_tag, imem_addr, m_pc);
            chk((want_rd || want_wr) ? cls : "R11", {30'd0, dmem_rd, dmem_wr}, {30'd0, want_rd, want_wr});
            if (want_rd || want_wr) chk(cls, dmem_addr, ea);
            if (want_wr) chk(m_wtag[rt], dmem_wdata, b);
            stall = (want_rd || want_wr) && !ack;
            if (stall) begin
                pc_tag = "R8";
            end else begin
                wr_en = 1'b1; dst = rt; res = 0;
                case (cls)
                    "R2": begin
                        dst = rd;
                        case (fn)
                            6'b100001: res = a + b;
                            6'b100011: res = a - b;
                            6'b100100: res = a & b;
                            6'b100101: res = a | b;
                            default:   res = ($signed(a) < $signed(b)) ? 1 : 0;
                        endcase
                    end
                    "R3": res = (op == 6'b001001) ? a + sx : (($signed(a) < $signed(sx)) ? 1 : 0);
                    "R4": res = (op == 6'b001100) ? (a & zx) : (a | zx);
                    "R5": res = mem[ea[6:2]];
                    default: wr_en = 1'b0;
                endcase
                if (want_wr) mem[ea[6:2]] = b;
                if (wr_en && dst != 0) begin
                    m_reg[dst]  = res;
                    m_wtag[dst] = cls;
                end
                if ((op == 6'b000100 && a == b) || (op == 6'b000101 && a != b))
                    m_pc = m_pc + 4 + {sx[29:0], 2'b00};
                else
                    m_pc = m_pc + 4;
                pc_tag = (wr_en && dst == 0) ? "R9" : cls;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = 0;
        for (int i = 0; i < 32; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        prog[0]  = e_i(6'b101011, 0, 5, 16'h40);      // reg clear check
        prog[1]  = e_i(6'b001001, 0, 1, 5);
        prog[2]  = e_i(6'b001001, 0, 2, 16'hFFFD);
        prog[3]  = e_r(6'b100001, 1, 2, 3);
        prog[4]  = e_r(6'b100011, 2, 1, 4);
        prog[5]  = e_r(6'b100100, 1, 2, 5);
        prog[6]  = e_r(6'b100101, 1, 2, 6);
        prog[7]  = e_r(6'b101010, 2, 1, 7);
        prog[8]  = e_r(6'b101010, 1, 2, 8);
        prog[9]  = e_i(6'b001100, 2, 9, 16'hFF00);
        prog[10] = e_i(6'b001101, 0, 10, 16'h8001);
        prog[11] = e_i(6'b001010, 2, 11, 0);
        for (int r = 3; r <= 11; r++) prog[12 + r - 3] = e_i(6'b101011, 0, r, 4 * (r - 3));
        prog[21] = e_i(6'b100011, 0, 12, 8);
        prog[22] = e_i(6'b001001, 0, 14, 16);
        prog[23] = e_i(6'b100011, 14, 13, 16'hFFFC);
        prog[24] = e_i(6'b101011, 13, 12, 16'h18);    // base from a load
        prog[25] = e_i(6'b101011, 0, 13, 16'h28);
        prog[26] = e_i(6'b001001, 0, 0, 7);
        prog[27] = e_i(6'b101011, 0, 0, 16'h2C);
        prog[28] = e_i(6'b000100, 1, 1, 2);
        prog[29] = e_i(6'b001001, 0, 15, 1);
        prog[30] = e_i(6'b001001, 0, 15, 2);
        prog[31] = e_i(6'b000100, 1, 2, 1);
        prog[32] = e_i(6'b000101, 1, 1, 1);
        prog[33] = e_i(6'b000101, 1, 2, 1);
        prog[34] = e_i(6'b001001, 0, 15, 3);
        prog[35] = e_i(6'b111111, 0, 15, 16'h1234);
        prog[36] = e_r(6'b000000, 1, 2, 15);
        prog[37] = e_i(6'b001001, 0, 22, 3);
        prog[38] = e_i(6'b001001, 20, 20, 1);
        prog[39] = e_i(6'b000101, 20, 22, 16'hFFFE);
        prog[40] = e_i(6'b101011, 0, 15, 16'h30);
        prog[41] = e_i(6'b101011, 0, 20, 16'h34);
        prog[42] = e_i(6'b000100, 0, 0, 16'hFFFF);

        do_reset();
        run_phase(0, 120);
        do_reset();
        run_phase(1, 250);
        do_reset();
        run_phase(2, 400);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        finish_run();
    end

endmodule